// File: doc/BRIEF.md
# Debug port protocol switch detector

This block decides whether a shared debug port behaves as a four-wire JTAG port or as a two-wire serial-wire port. It samples the mode-select line on every rising edge of the debug clock. A switch is recognised when that line has stayed at 1 for a long run of cycles and is then followed by a fixed 16-bit selection word, sent least significant bit first. When the word matches, the block hands the port to the other protocol. It raises a single-cycle pulse to tell the surrounding logic that the mode has changed.

Each mode accepts only one selection word: the one that leads to the other mode. A word that does not match, or that names the mode already in force, is dropped. The search then starts again from a fresh run of ones. The trailing run of ones that a host sends after the word belongs to the line-reset handling of the new protocol and is not examined here.

Top module: `dbg_proto_sel`

## Requirements
- R1: While `por_n` is low, and after it is released, `jtag_en_o` is 1, `sw_en_o` is 0 and `switch_pulse_o` is 0.
- R2: Exactly one of `jtag_en_o` and `sw_en_o` is 1 in every cycle.
- R3: A selection word is considered only after at least 50 consecutive samples of `tms_i` = 1. With 49 ones the word is ignored; 50, 55 or 120 ones all qualify.
- R4: A sample of 0 that arrives before the run reaches 50 clears the run, and counting starts again from zero.
- R5: In JTAG mode, once the run qualifies, the first 0 sampled is bit 0 of the word. If the 16 samples from that 0 onward equal 0xE79E taken bit 0 first, the port switches to serial-wire mode.
- R6: In serial-wire mode, the word 0xE73C (bit 0 first), placed after a qualifying run in the same way, switches the port back to JTAG mode.
- R7: A correctly formed word for the mode already active (0xE73C in JTAG mode, 0xE79E in serial-wire mode) changes nothing and produces no pulse.
- R8: If any one of bits 1 to 15 of the word differs from the expected value, there is no switch and no pulse.
- R9: The enables change at the clock edge that samples bit 15 of a matching word. `switch_pulse_o` is 1 for exactly the cycle after that edge and for no other cycle.
- R10: After a mismatching bit, the run counter starts again at the first 1 sampled after that bit; the mismatching bit itself is not counted. A mismatching 1 followed by 49 ones does not qualify; followed by 50 ones it does.
- R11: The run counter saturates. A run much longer than 50 still qualifies, and it stays qualified until a 0 is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Debug clock; all state changes on its rising edge |
| por_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| tms_i | input | 1 | Mode-select line |
| jtag_en_o | output | 1 | 1 while the port acts as a JTAG port |
| sw_en_o | output | 1 | 1 while the port acts as a serial-wire port |
| switch_pulse_o | output | 1 | One-cycle pulse in the cycle after a mode change |

## Verification
Every result here is due one register stage after the sample that causes it. The enables and the pulse change at the same rising edge that samples bit 15. The run and match state advance at the edge that samples each bit. The bench therefore drives `tms_i` on the falling edge and reads the outputs shortly after the next rising edge. It expects the pulse exactly at the read that follows bit 15 and checks the enables at that read. Because the reset is released through a two-stage synchroniser, the bench idles with `tms_i` at 0 for several cycles after release before it sends anything. Sweeps cover run lengths around the threshold, a corruption at each word position in both modes, and the restart of the run after a mismatching bit.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic {
    MODE_JTAG = 1'b0,
    MODE_SW   = 1'b1
  } dbg_mode_e;

  typedef enum logic {
    MS_HUNT = 1'b0,
    MS_CAPT = 1'b1
  } match_st_e;

  localparam int unsigned DPS_MIN_RUN = 50;
  localparam int unsigned DPS_PAT_W   = 16;
  localparam logic [DPS_PAT_W-1:0] DPS_KEY_TO_SW   = 16'hE79E;
  localparam logic [DPS_PAT_W-1:0] DPS_KEY_TO_JTAG = 16'hE73C;

endpackage

// File: rtl/dps_reset_sync.sv
module dps_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/dps_run_counter.sv
module dps_run_counter #(
  parameter int unsigned MIN_RUN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tms_i,
  input  logic clr_i,
  output logic armed_o
);

  localparam int unsigned CNT_W = $clog2(MIN_RUN + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_RUN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    if (clr_i || !tms_i) begin
      cnt_d = '0;
    end else if (cnt_q != SAT) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed_o = (cnt_q == SAT);

  // R11
  run_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT);

  // R11
  run_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && tms_i) |=> armed_o);

  // R4
  run_zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tms_i && !armed_o) |=> (cnt_q == '0));

endmodule

// File: rtl/dps_pattern_match.sv
module dps_pattern_match
  import dps_pkg::*;
#(
  parameter int unsigned          PAT_W   = 16,
  parameter logic [PAT_W-1:0]     KEY_SW  = 16'hE79E,
  parameter logic [PAT_W-1:0]     KEY_JTG = 16'hE73C
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tms_i,
  input  logic      armed_i,
  input  dbg_mode_e mode_i,
  output logic      busy_o,
  output logic      start_o,
  output logic      abort_o,
  output logic      hit_o
);

  localparam int unsigned IDX_W = $clog2(PAT_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAT_W - 1);

  match_st_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PAT_W-1:0] key;
  logic             exp_bit;

  assign key     = (mode_i == MODE_JTAG) ? KEY_SW : KEY_JTG;
  assign exp_bit = key[idx_q];

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    start_o = 1'b0;
    abort_o = 1'b0;
    hit_o   = 1'b0;
    unique case (st_q)
      MS_HUNT: begin
        if (armed_i && (tms_i == key[0])) begin
          start_o = 1'b1;
          st_d    = MS_CAPT;
          idx_d   = IDX_W'(1);
        end
      end
      MS_CAPT: begin
        if (tms_i != exp_bit) begin
          abort_o = 1'b1;
          st_d    = MS_HUNT;
          idx_d   = '0;
        end else if (idx_q == LAST) begin
          hit_o   = 1'b1;
          st_d    = MS_HUNT;
          idx_d   = '0;
        end else begin
          idx_d   = idx_q + 1'b1;
        end
      end
      default: begin
        st_d  = MS_HUNT;
        idx_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_HUNT;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy_o = (st_q == MS_CAPT);

  // R5
  capture_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(armed_i) && !$past(tms_i)));

  // R8
  abort_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !busy_o);

  // R9
  hit_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !busy_o);

  // R8
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, abort_o, hit_o}));

endmodule

// File: rtl/dps_mode_reg.sv
module dps_mode_reg
  import dps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_i,
  output dbg_mode_e mode_o,
  output logic      pulse_o
);

  dbg_mode_e mode_q, mode_d;
  logic      pulse_q;

  always_comb begin
    mode_d = mode_q;
    if (hit_i) mode_d = (mode_q == MODE_JTAG) ? MODE_SW : MODE_JTAG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_JTAG;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pulse_q <= hit_i;
    end
  end

  assign mode_o  = mode_q;
  assign pulse_o = pulse_q;

  // R9
  pulse_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (mode_q != $past(mode_q)));

  // R9
  quiet_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_o |-> $stable(mode_q));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/dbg_proto_sel.sv
module dbg_proto_sel
  import dps_pkg::*;
#(
  parameter int unsigned                MIN_RUN   = DPS_MIN_RUN,
  parameter int unsigned                PAT_W     = DPS_PAT_W,
  parameter logic [PAT_W-1:0]           KEY_SW    = DPS_KEY_TO_SW,
  parameter logic [PAT_W-1:0]           KEY_JTG   = DPS_KEY_TO_JTAG,
  parameter int unsigned                RST_STAGES = 2
) (
  input  logic tck,
  input  logic por_n,
  input  logic tms_i,
  output logic jtag_en_o,
  output logic sw_en_o,
  output logic switch_pulse_o
);

  logic      rst_n;
  logic      armed;
  logic      busy;
  logic      start;
  logic      abort;
  logic      hit;
  logic      run_clr;
  dbg_mode_e mode;

  dps_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (tck),
    .arst_n  (por_n),
    .rst_n_o (rst_n)
  );

  assign run_clr = start | busy | abort;

  dps_run_counter #(.MIN_RUN(MIN_RUN)) u_run (
    .clk     (tck),
    .rst_n   (rst_n),
    .tms_i   (tms_i),
    .clr_i   (run_clr),
    .armed_o (armed)
  );

  dps_pattern_match #(
    .PAT_W   (PAT_W),
    .KEY_SW  (KEY_SW),
    .KEY_JTG (KEY_JTG)
  ) u_match (
    .clk     (tck),
    .rst_n   (rst_n),
    .tms_i   (tms_i),
    .armed_i (armed),
    .mode_i  (mode),
    .busy_o  (busy),
    .start_o (start),
    .abort_o (abort),
    .hit_o   (hit)
  );

  dps_mode_reg u_mode (
    .clk     (tck),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .mode_o  (mode),
    .pulse_o (switch_pulse_o)
  );

  assign jtag_en_o = (mode == MODE_JTAG);
  assign sw_en_o   = (mode == MODE_SW);

  // R2
  enable_onehot_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $countones({jtag_en_o, sw_en_o}) == 1);

  // R3
  hit_needs_run_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

endmodule

// File: tb/tb_dbg_proto_sel.sv
`timescale 1ns/1ps
module tb_dbg_proto_sel;

  localparam logic [15:0] K_SW  = 16'hE79E;
  localparam logic [15:0] K_JTG = 16'hE73C;

  logic tck = 1'b0;
  logic por_n;
  logic tms;
  logic jtag_en, sw_en, pulse;

  int n_chk = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  int excl_err = 0;
  int pulse_run_err = 0;
  logic prev_pulse = 1'b0;
  logic done = 1'b0;

  always #2 tck = ~tck;

  dbg_proto_sel dut (
    .tck            (tck),
    .por_n          (por_n),
    .tms_i          (tms),
    .jtag_en_o      (jtag_en),
    .sw_en_o        (sw_en),
    .switch_pulse_o (pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge tck);
    tms = b;
    @(posedge tck);
    #1;
    if ((int'(jtag_en) + int'(sw_en)) != 1) excl_err++;
    if (pulse) pulse_cnt++;
    if (pulse && prev_pulse) pulse_run_err++;
    prev_pulse = pulse;
  endtask

  task automatic drive_ones(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic do_reset();
    @(negedge tck);
    por_n = 1'b0;
    tms   = 1'b0;
    repeat (3) @(negedge tck);
    chk("R1", "jtag_en in reset", int'(jtag_en), 1);
    chk("R1", "sw_en in reset", int'(sw_en), 0);
    chk("R1", "pulse in reset", int'(pulse), 0);
    por_n = 1'b1;
    prev_pulse = 1'b0;
    for (int i = 0; i < 4; i++) drive_bit(1'b0);
    chk("R1", "jtag_en after reset", int'(jtag_en), 1);
    chk("R1", "sw_en after reset", int'(sw_en), 0);
    chk("R1", "pulse after reset", int'(pulse), 0);
  endtask

  // run of ones, 16-bit word LSB first (bit corrupt_idx inverted, -1 none), short tail
  task automatic send(input int run_len, input logic [15:0] key, input int corrupt_idx,
                      input int exp_sw, input string req);
    int p0;
    int at15;
    p0 = pulse_cnt;
    at15 = 0;
    drive_ones(run_len);
    for (int i = 0; i < 16; i++) begin
      drive_bit(key[i] ^ (i == corrupt_idx));
      if (i == 15) at15 = int'(pulse);
    end
    drive_ones(20);
    for (int i = 0; i < 3; i++) drive_bit(1'b0);
    chk(req, "pulses in sequence", pulse_cnt - p0, exp_sw);
    chk(req, "pulse right after bit 15", at15, exp_sw);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0;
    tms   = 1'b0;

    // R3 R5 R9 R11: run-length sweep around the threshold, plus a long run
    for (int r = 45; r <= 56; r++) begin
      int rl;
      rl = (r == 56) ? 120 : r;
      do_reset();
      send(rl, K_SW, -1, (rl >= 50) ? 1 : 0, "R3");
      chk("R5", "sw_en after word", int'(sw_en), (rl >= 50) ? 1 : 0);
      chk("R9", "jtag_en after word", int'(jtag_en), (rl >= 50) ? 0 : 1);
    end

    // R4: a zero inside the run clears it
    do_reset();
    drive_ones(49);
    drive_bit(1'b0);
    send(49, K_SW, -1, 0, "R4");
    chk("R4", "jtag_en after broken run", int'(jtag_en), 1);
    drive_ones(30);
    drive_bit(1'b0);
    send(50, K_SW, -1, 1, "R4");
    chk("R4", "sw_en after fresh run", int'(sw_en), 1);

    // R7: word for the active mode in JTAG mode
    do_reset();
    send(60, K_JTG, -1, 0, "R7");
    chk("R7", "jtag_en kept", int'(jtag_en), 1);

    // R8: single-bit corruption sweep in JTAG mode
    for (int k = 1; k < 16; k++) begin
      send(55, K_SW, k, 0, "R8");
      chk("R8", "jtag_en kept after corrupt", int'(jtag_en), 1);
    end

    // R5: switch to serial-wire
    send(50, K_SW, -1, 1, "R5");
    chk("R5", "sw_en", int'(sw_en), 1);

    // R8: corruption sweep in serial-wire mode
    for (int k = 1; k < 16; k++) begin
      send(55, K_JTG, k, 0, "R8");
      chk("R8", "sw_en kept after corrupt", int'(sw_en), 1);
    end

    // R7: word for the active mode in serial-wire mode
    send(70, K_SW, -1, 0, "R7");
    chk("R7", "sw_en kept", int'(sw_en), 1);

    // R6: back to JTAG
    send(50, K_JTG, -1, 1, "R6");
    chk("R6", "jtag_en restored", int'(jtag_en), 1);
    chk("R6", "sw_en cleared", int'(sw_en), 0);

    // R10: mismatching 1 at bit 5 is not counted toward the next run
    drive_ones(50);
    for (int i = 0; i < 5; i++) drive_bit(K_SW[i]);
    drive_bit(1'b1);
    send(49, K_SW, -1, 0, "R10");
    chk("R10", "jtag_en after 49 ones", int'(jtag_en), 1);
    drive_ones(50);
    for (int i = 0; i < 5; i++) drive_bit(K_SW[i]);
    drive_bit(1'b1);
    send(50, K_SW, -1, 1, "R10");
    chk("R10", "sw_en after 50 ones", int'(sw_en), 1);

    // R2 R9 whole-run observations
    chk("R2", "cycles with enables not one-hot", excl_err, 0);
    chk("R9", "pulses longer than one cycle", pulse_run_err, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule